// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects interrupt flags from the peripherals of a small 8-bit microcontroller. Three of its nine sources are the OR of two flags: serial receive or transmit, timer 2 overflow or external, and the two flags of the I2C/SPI port. Each source has its own enable bit and its own priority bit, and one global enable gates all of them. The block picks one request to present to the CPU and supplies a fixed vector address for it.

Two in-service flags, one for each level, carry the nesting rules. A routine running at low level can be preempted only by a high-level request. A routine running at high level cannot be preempted at all. Requests at the same level are resolved by a fixed polling order.

The CPU sees a request line together with a vector and a source index, which are held until the CPU acknowledges. A one-cycle return strobe tells the block that the innermost routine has finished.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, irqReq is low, no level is in service, and all four control registers read 0x00.
- R2: The control registers are written through regWrEn/regAddr/regWrData and read back combinationally on regRdData. The registers are:
  - 0xA8, main enable. Bit 7 is the global enable. Bits 0..6 enable external 0, timer 0, external 1, timer 1, serial, timer 2 and ADC.
  - 0xB8, main priority. It uses the same bit positions as the main enable. Bit 7 reads as 0.
  - 0xA9, secondary enable. Bit 1 enables the power monitor and bit 0 enables I2C/SPI. Bits 7..2 read as 0.
  - 0xB9, secondary priority. It uses the same layout as 0xA9.
  - Any other address reads 0x00.
  - A priority bit of 1 means high level.
- R3: A source is a candidate only when its flag, its enable bit and the global enable are all set. A flag that is set before a clock edge raises irqReq after the next edge but one.
- R4: The serial source is rxFlag OR txFlag. The timer 2 source is tmr2OvfFlag OR tmr2ExtFlag. The I2C/SPI source is i2cFlag OR spiFlag.
- R5: When candidates of both levels are pending, a high-level one is presented first.
- R6: Within a level, the winner follows this polling rank, where srcIdx equals the rank: 0 power monitor, 1 external 0, 2 ADC, 3 timer 0, 4 external 1, 5 timer 1, 6 I2C/SPI, 7 serial, 8 timer 2.
- R7: irqVec is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1, 0x0023 for serial, 0x002B for timer 2, 0x0033 for ADC, 0x003B for I2C/SPI and 0x0043 for the power monitor.
- R8: Once irqReq rises, it stays high with irqVec and srcIdx unchanged until an irqAck is seen on a clock edge. After that edge irqReq is low.
- R9: An acknowledge marks the served level as in service. While high is in service, no request is presented. While only low is in service, only high-level requests are presented.
- R10: A retiPulse clears the high in-service flag if it is set, and otherwise clears the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pmonFlag | input | 1 | Power monitor flag |
| ext0Flag | input | 1 | External interrupt 0 flag |
| adcFlag | input | 1 | ADC flag |
| tmr0Flag | input | 1 | Timer 0 flag |
| ext1Flag | input | 1 | External interrupt 1 flag |
| tmr1Flag | input | 1 | Timer 1 flag |
| i2cFlag | input | 1 | I2C port flag |
| spiFlag | input | 1 | SPI port flag |
| rxFlag | input | 1 | Serial receive flag |
| txFlag | input | 1 | Serial transmit flag |
| tmr2OvfFlag | input | 1 | Timer 2 overflow flag |
| tmr2ExtFlag | input | 1 | Timer 2 external flag |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| irqAck | input | 1 | CPU accepts the presented vector |
| retiPulse | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Request presented to the CPU |
| irqVec | output | 16 | Vector address of the presented source |
| srcIdx | output | 4 | Polling rank of the presented source |

## Verification
The bench builds the block with its default parameters. These are the four register addresses 0xA8, 0xB8, 0xA9 and 0xB9, a 16-bit vector, a base offset of 3 and a stride of 8, so every vector address listed in R7 is reachable and can be compared literally. With these values, random register contents and sparse random flag patterns drive all nine ranks. They also reach every nesting state, from nothing in service through low only to high.

The OR-paired inputs are each driven alone in directed cases. A late high-level flag arriving during an unacknowledged low offer shows that the held vector does not move.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int NUM_SRC = 9;
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int NUM_RAW = 12;

  typedef struct packed {
    logic latchSel;
    logic setSvcHi;
    logic setSvcLo;
    logic clrSvcHi;
    logic clrSvcLo;
  } ctrl_strobe_t;

  // polling rank to vector slot (slot * stride + base gives the address)
  function automatic logic [IDX_W-1:0] rankToSlot(input logic [IDX_W-1:0] rank);
    case (rank)
      4'd0: rankToSlot = 4'd8;
      4'd1: rankToSlot = 4'd0;
      4'd2: rankToSlot = 4'd6;
      4'd3: rankToSlot = 4'd1;
      4'd4: rankToSlot = 4'd2;
      4'd5: rankToSlot = 4'd3;
      4'd6: rankToSlot = 4'd7;
      4'd7: rankToSlot = 4'd4;
      4'd8: rankToSlot = 4'd5;
      default: rankToSlot = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/nest_irq_dp.sv
module nest_irq_dp
  import nest_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int VEC_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'hA8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'hB8,
  parameter logic [ADDR_W-1:0] SEC_EN_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] SEC_PRI_ADDR = 8'hB9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_RAW-1:0]  rawFlags,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  ctrl_strobe_t        strobe,
  output logic                candValid,
  output logic                selHigh,
  output logic                svcHi,
  output logic                svcLo,
  output logic [VEC_W-1:0]    irqVec,
  output logic [IDX_W-1:0]    srcIdx
);
  localparam int MAIN_BITS = 7;
  localparam int SEC_BITS = 2;
  localparam int GLOBAL_BIT = DATA_W - 1;

  logic [DATA_W-1:0]    enMain;
  logic [MAIN_BITS-1:0] prMain;
  logic [SEC_BITS-1:0]  enSec;
  logic [SEC_BITS-1:0]  prSec;
  logic [NUM_SRC-1:0]   pendQ;
  logic [NUM_SRC-1:0]   pendNext;
  logic [NUM_SRC-1:0]   enVec;
  logic [NUM_SRC-1:0]   prVec;
  logic [NUM_SRC-1:0]   gated;
  logic [NUM_SRC-1:0]   hiReq;
  logic [NUM_SRC-1:0]   loReq;
  logic [IDX_W-1:0]     hiPick;
  logic [IDX_W-1:0]     loPick;
  logic                 hiOk;
  logic                 loOk;
  logic [IDX_W-1:0]     candRank;
  logic [IDX_W-1:0]     selRank;

  // Raw flag order: pmon, ext0, adc, tmr0, ext1, tmr1, i2c, spi, rx, tx, t2ovf, t2ext
  localparam int NUM_PAIRS = 3;
  generate
    for (genvar s = 0; s < 6; s++) begin : g_single
      assign pendNext[s] = rawFlags[s];
    end
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign pendNext[6+p] = rawFlags[6+2*p] | rawFlags[7+2*p];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMain <= '0;
      prMain <= '0;
      enSec  <= '0;
      prSec  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        EN_ADDR:      enMain <= regWrData;
        PRI_ADDR:     prMain <= regWrData[MAIN_BITS-1:0];
        SEC_EN_ADDR:  enSec  <= regWrData[SEC_BITS-1:0];
        SEC_PRI_ADDR: prSec  <= regWrData[SEC_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      EN_ADDR:      regRdData = enMain;
      PRI_ADDR:     regRdData[MAIN_BITS-1:0] = prMain;
      SEC_EN_ADDR:  regRdData[SEC_BITS-1:0] = enSec;
      SEC_PRI_ADDR: regRdData[SEC_BITS-1:0] = prSec;
      default:      regRdData = '0;
    endcase
  end

  // per-rank enable and priority (main bits: ext0,tmr0,ext1,tmr1,serial,tmr2,adc)
  assign enVec = {enMain[5], enMain[4], enSec[0], enMain[3], enMain[2],
                  enMain[1], enMain[6], enMain[0], enSec[1]};
  assign prVec = {prMain[5], prMain[4], prSec[0], prMain[3], prMain[2],
                  prMain[1], prMain[6], prMain[0], prSec[1]};

  assign gated = pendQ & enVec & {NUM_SRC{enMain[GLOBAL_BIT]}};
  assign hiReq = gated & prVec;
  assign loReq = gated & ~prVec;

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    firstSet = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) firstSet = IDX_W'(i);
    end
  endfunction

  assign hiPick = firstSet(hiReq);
  assign loPick = firstSet(loReq);
  assign hiOk = !svcHi && (|hiReq);
  assign loOk = !svcHi && !svcLo && (|loReq);
  assign candValid = hiOk || loOk;
  assign candRank = hiOk ? hiPick : loPick;

  // selection latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRank <= '0;
      selHigh <= 1'b0;
    end else if (strobe.latchSel) begin
      selRank <= candRank;
      selHigh <= hiOk;
    end
  end

  // in-service flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcHi <= 1'b0;
      svcLo <= 1'b0;
    end else begin
      svcHi <= (svcHi && !strobe.clrSvcHi) || strobe.setSvcHi;
      svcLo <= (svcLo && !strobe.clrSvcLo) || strobe.setSvcLo;
    end
  end

  assign srcIdx = selRank;
  assign irqVec = VEC_W'(VEC_BASE) + VEC_W'(rankToSlot(selRank)) * VEC_W'(VEC_STRIDE);

  // R8: vector only moves on a latch strobe
  assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchSel |=> $stable(irqVec) && $stable(srcIdx));
  // R3: control never latches without a candidate
  assert_latch_needs_cand_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchSel |-> candValid);
  // R9: at most one level marked per acknowledge
  assert_one_level_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setSvcHi, strobe.setSvcLo}));
endmodule

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl
  import nest_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         candValid,
  input  logic         selHigh,
  input  logic         svcHi,
  input  logic         svcLo,
  input  logic         irqAck,
  input  logic         retiPulse,
  output ctrl_strobe_t strobe,
  output logic         irqReq
);
  typedef enum logic {ST_IDLE, ST_OFFER} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (candValid) begin
          strobe.latchSel = 1'b1;
          stateNext = ST_OFFER;
        end
      end
      ST_OFFER: begin
        if (irqAck) begin
          strobe.setSvcHi = selHigh;
          strobe.setSvcLo = !selHigh;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (retiPulse) begin
      strobe.clrSvcHi = svcHi;
      strobe.clrSvcLo = !svcHi && svcLo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign irqReq = (state == ST_OFFER);

  // R8: offer held until acknowledged
  assert_offer_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);
  // R9: nothing new offered while high level is in service
  assert_hi_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> !$past(svcHi));
  // R9: acknowledge leaves a level in service
  assert_ack_marks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> (svcHi || svcLo));
  // R10: return clears the high flag first
  assert_reti_hi_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !irqAck && svcHi) |=> !svcHi);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int VEC_W = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR = 8'hA8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'hB8,
  parameter logic [ADDR_W-1:0] SEC_EN_ADDR = 8'hA9,
  parameter logic [ADDR_W-1:0] SEC_PRI_ADDR = 8'hB9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pmonFlag,
  input  logic              ext0Flag,
  input  logic              adcFlag,
  input  logic              tmr0Flag,
  input  logic              ext1Flag,
  input  logic              tmr1Flag,
  input  logic              i2cFlag,
  input  logic              spiFlag,
  input  logic              rxFlag,
  input  logic              txFlag,
  input  logic              tmr2OvfFlag,
  input  logic              tmr2ExtFlag,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              irqAck,
  input  logic              retiPulse,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVec,
  output logic [IDX_W-1:0]  srcIdx
);
  logic [NUM_RAW-1:0] rawFlags;
  ctrl_strobe_t strobe;
  logic candValid, selHigh, svcHi, svcLo;

  assign rawFlags = {tmr2ExtFlag, tmr2OvfFlag, txFlag, rxFlag, spiFlag, i2cFlag,
                     tmr1Flag, ext1Flag, tmr0Flag, adcFlag, ext0Flag, pmonFlag};

  nest_irq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .EN_ADDR(EN_ADDR), .PRI_ADDR(PRI_ADDR),
    .SEC_EN_ADDR(SEC_EN_ADDR), .SEC_PRI_ADDR(SEC_PRI_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawFlags(rawFlags),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .candValid(candValid), .selHigh(selHigh),
    .svcHi(svcHi), .svcLo(svcLo), .irqVec(irqVec), .srcIdx(srcIdx)
  );

  nest_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .candValid(candValid), .selHigh(selHigh),
    .svcHi(svcHi), .svcLo(svcLo), .irqAck(irqAck), .retiPulse(retiPulse),
    .strobe(strobe), .irqReq(irqReq)
  );
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // bench flag order: pmon ext0 adc tmr0 ext1 tmr1 i2c spi rx tx t2ovf t2ext
  logic [11:0] fl = '0;
  logic wrEn = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic ack = 1'b0, reti = 1'b0;
  logic req;
  logic [15:0] vec;
  logic [3:0] idx;
  int nChecks = 0, nErrors = 0;
  bit done = 0;

  logic [7:0] mEn = '0, mPr = '0;
  logic [1:0] mSecEn = '0, mSecPr = '0;
  bit mHi = 0, mLo = 0;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rstN(rstN),
    .pmonFlag(fl[0]), .ext0Flag(fl[1]), .adcFlag(fl[2]), .tmr0Flag(fl[3]),
    .ext1Flag(fl[4]), .tmr1Flag(fl[5]), .i2cFlag(fl[6]), .spiFlag(fl[7]),
    .rxFlag(fl[8]), .txFlag(fl[9]), .tmr2OvfFlag(fl[10]), .tmr2ExtFlag(fl[11]),
    .regWrEn(wrEn), .regAddr(addr), .regWrData(wdata), .regRdData(rdata),
    .irqAck(ack), .retiPulse(reti), .irqReq(req), .irqVec(vec), .srcIdx(idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pollOf(input logic [11:0] f);
    return {f[11] | f[10], f[9] | f[8], f[7] | f[6], f[5], f[4], f[3], f[2], f[1], f[0]};
  endfunction

  function automatic bit enOf(input int r);
    case (r)
      0: return mSecEn[1];  1: return mEn[0];  2: return mEn[6];
      3: return mEn[1];     4: return mEn[2];  5: return mEn[3];
      6: return mSecEn[0];  7: return mEn[4];  default: return mEn[5];
    endcase
  endfunction

  function automatic bit prOf(input int r);
    case (r)
      0: return mSecPr[1];  1: return mPr[0];  2: return mPr[6];
      3: return mPr[1];     4: return mPr[2];  5: return mPr[3];
      6: return mSecPr[0];  7: return mPr[4];  default: return mPr[5];
    endcase
  endfunction

  function automatic logic [15:0] expVec(input int r);
    case (r)
      0: return 16'h0043;  1: return 16'h0003;  2: return 16'h0033;
      3: return 16'h000B;  4: return 16'h0013;  5: return 16'h001B;
      6: return 16'h003B;  7: return 16'h0023;  default: return 16'h002B;
    endcase
  endfunction

  task automatic expSel(input logic [11:0] f, output bit v, output int r, output bit h);
    logic [8:0] p;
    p = pollOf(f);
    v = 0; r = 0; h = 0;
    if (mEn[7] && !mHi) begin
      for (int i = 0; i < 9; i++)
        if (!v && p[i] && enOf(i) && prOf(i)) begin v = 1; r = i; h = 1; end
      if (!v && !mLo)
        for (int i = 0; i < 9; i++)
          if (!v && p[i] && enOf(i) && !prOf(i)) begin v = 1; r = i; end
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic setRegs(input logic [7:0] en, input logic [7:0] pr,
                         input logic [1:0] se, input logic [1:0] sp);
    writeReg(8'hA8, en); writeReg(8'hB8, pr);
    writeReg(8'hA9, {6'd0, se}); writeReg(8'hB9, {6'd0, sp});
    mEn = en; mPr = {1'b0, pr[6:0]}; mSecEn = se; mSecPr = sp;
  endtask

  task automatic doReti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    if (mHi) mHi = 0; else mLo = 0;
  endtask

  // R3 R5 R6 R7 R9 checked per trial against the model
  task automatic trial(input logic [11:0] f, input string tag);
    bit v, h; int r;
    @(negedge clk);
    fl = f;
    expSel(f, v, r, h);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check({tag, " R3 irqReq"}, req, v);
    if (v) begin
      check({tag, " R6 srcIdx"}, idx, r);
      check({tag, " R7 irqVec"}, vec, expVec(r));
      ack = 1; fl = '0;
      @(negedge clk);
      ack = 0;
      if (h) mHi = 1; else mLo = 1;
      check({tag, " R8 drop after ack"}, req, 0);
    end else begin
      fl = '0;
    end
    @(negedge clk); @(negedge clk);
    check({tag, " R9 idle"}, req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [11:0] hf;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqReq", req, 0);
    foreach (hf[i]) ;
    addr = 8'hA8; #1 check("R1 enable", rdata, 0);
    addr = 8'hB8; #1 check("R1 priority", rdata, 0);
    addr = 8'hA9; #1 check("R1 sec enable", rdata, 0);
    addr = 8'hB9; #1 check("R1 sec priority", rdata, 0);
    trial(12'hFFF, "R1 all flags, nothing enabled");

    // R2 readback and reserved bits
    setRegs(8'hFF, 8'hFF, 2'b11, 2'b11);
    writeReg(8'hA9, 8'hFF); writeReg(8'hB9, 8'hFF);
    @(negedge clk);
    addr = 8'hA8; #1 check("R2 enable readback", rdata, 8'hFF);
    addr = 8'hB8; #1 check("R2 priority bit7 zero", rdata, 8'h7F);
    addr = 8'hA9; #1 check("R2 sec enable reserved zero", rdata, 8'h03);
    addr = 8'hB9; #1 check("R2 sec priority reserved zero", rdata, 8'h03);
    addr = 8'h00; #1 check("R2 unmapped address", rdata, 8'h00);

    // R3 global enable off
    setRegs(8'h7F, 8'h00, 2'b11, 2'b00);
    trial(12'hFFF, "R3 global off");
    check("R3 global off no req", req, 0);

    // R4 each half of the paired sources
    setRegs(8'hFF, 8'h00, 2'b11, 2'b00);
    trial(12'h200, "R4 tx alone"); doReti();
    trial(12'h100, "R4 rx alone"); doReti();
    trial(12'h080, "R4 spi alone"); doReti();
    trial(12'h040, "R4 i2c alone"); doReti();
    trial(12'h800, "R4 t2 ext alone"); doReti();
    trial(12'h400, "R4 t2 ovf alone"); doReti();

    // R6 polling order within low level
    trial(12'hFFF, "R6 all low -> pmon"); doReti();
    trial(12'hFFE, "R6 no pmon -> ext0"); doReti();
    trial(12'hFFC, "R6 -> adc"); doReti();
    trial(12'h0C0, "R6 i2c/spi beats later"); doReti();

    // R5 high beats low: timer 2 high, pmon low
    setRegs(8'hFF, 8'h20, 2'b11, 2'b00);
    trial(12'hC01, "R5 high t2 over low pmon");
    check("R5 high in service", mHi, 1);

    // R9 nesting: with high in service nothing, after reti low works, then high preempts
    trial(12'hFFF, "R9 high in service blocks");
    doReti();
    trial(12'h001, "R9 low pmon taken");
    trial(12'h002, "R9 low blocked by low");
    trial(12'h400, "R9 high preempts low");
    trial(12'h800, "R9 nested high blocks");
    // R10 reti clears high first, then low
    doReti();
    trial(12'h002, "R10 low still in service");
    doReti();
    trial(12'h002, "R10 low cleared");
    doReti();

    // R8 hold with a later higher request
    setRegs(8'hFF, 8'h00, 2'b10, 2'b10);
    @(negedge clk); fl = 12'h010;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 ext1 offered", req, 1);
    fl = 12'h011;
    repeat (5) @(negedge clk);
    check("R8 still offered", req, 1);
    check("R8 vector held", vec, 16'h0013);
    check("R8 index held", idx, 4);
    ack = 1; fl = '0;
    @(negedge clk); ack = 0; mLo = 1;
    check("R8 drop after ack", req, 0);
    repeat (2) @(negedge clk);
    doReti();

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [7:0] en;
      en = 8'($urandom);
      if (($urandom % 8) != 0) en[7] = 1'b1;
      setRegs(en, 8'($urandom), 2'($urandom), 2'($urandom));
      trial(12'($urandom) & 12'($urandom), "random");
      if (($urandom % 2) == 0) doReti();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule